// File: doc/BRIEF.md
# Grant/Release Ownership Tracker

This block follows, line by line across a small address space, the permission the local agent holds (none, shared or exclusive) and a logical timestamp for each line. Two event streams come in: grants, which carry an address, a time, a data word and the permission handed over, and releases, which carry an address, a time and a data word. A legal event updates the line's permission, its timestamp and, where the rules call for it, a stored copy of the line's data word. It also moves a running local clock forward. An illegal event changes nothing and raises a one-cycle error pulse.

Events arrive through valid/ready pairs, and at most one is taken per cycle. A grant always wins over a release presented in the same cycle. A query port reports the permission, timestamp and data copy of any line, so the surrounding logic (or a bench) can see the tracked state.

The data copy follows one rule. Two events on the same line at the same logical time must agree on the data. An event at a later time records a new value. A release from shared permission carries no data obligation.

Top module: `own_tracker`

## Requirements
- R1: After reset every line reads permission none (code 0), timestamp 0 and data 0; the local clock reads 0 and the error output is low.
- R2: A grant is legal only when the line is at none and the granted permission is shared (code 1) or exclusive (code 2). A legal grant sets the line to the granted code. A grant carrying code 0 or 3, or aimed at an owned line, is illegal.
- R3: A release is legal only when the line is shared or exclusive, and a legal release always sets it to none. A release of a line at none is illegal.
- R4: An event whose time is below the line's timestamp is illegal. A legal event sets the line's timestamp to the event time.
- R5: After a legal event the local clock becomes the larger of its old value and the event time. It never moves backwards.
- R6: A grant, or a release of an exclusive line, whose time equals the line's timestamp must carry data equal to the stored copy, or it is illegal. When such an event is legal and its time is later, its data becomes the new stored copy.
- R7: An illegal accepted event drives the error output high in the cycle after it is taken, for that cycle only. It leaves every line and the local clock unchanged.
- R8: The grant input is always ready. The release input is ready only while no grant is valid, so a grant wins when both are valid.
- R9: A release of a shared line ignores its data: there is no data check, and the stored copy stays as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gnt_valid | input | 1 | Grant event present |
| gnt_ready | output | 1 | Grant event accepted |
| gnt_addr | input | 4 | Grant line index |
| gnt_time | input | 8 | Grant logical time |
| gnt_data | input | 32 | Grant data word |
| gnt_perm | input | 2 | Granted permission: 1 shared, 2 exclusive |
| rel_valid | input | 1 | Release event present |
| rel_ready | output | 1 | Release event accepted |
| rel_addr | input | 4 | Release line index |
| rel_time | input | 8 | Release logical time |
| rel_data | input | 32 | Release data word |
| err_pulse | output | 1 | One-cycle flag for an illegal event |
| local_time | output | 8 | Running local logical clock |
| qry_addr | input | 4 | Line to report |
| qry_perm | output | 2 | Permission of the reported line |
| qry_time | output | 8 | Timestamp of the reported line |
| qry_data | output | 32 | Stored data copy of the reported line |

## Verification
The bench targets the equal-time cases. A grant or exclusive release at exactly the line's timestamp with wrong data must be refused. A design that compared times strictly, or skipped the data test, would accept it and corrupt the copy. A shared release with garbage data must pass and leave the copy alone, which catches a design that checks or stores data regardless of permission. Events that go backwards in time, doubled grants, releases of unowned lines and grants with permission code 0 or 3 must each raise the error and freeze all state. Clocks that move anyway, or an error that fires a cycle early, show up at once against the per-cycle model. Cycles in which both inputs are valid confirm that the grant wins and the release is held off.

// File: rtl/own_pkg.sv
package own_pkg;
  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_SHRD = 2'd1,
    PERM_EXCL = 2'd2
  } perm_e;
endpackage

// File: rtl/own_line_store.sv
module own_line_store
  import own_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TW    = 8,
  parameter int DW    = 32,
  localparam int AW   = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  perm_e         wr_perm,
  input  logic [TW-1:0] wr_time,
  input  logic          wr_data_en,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output perm_e         rd_perm,
  output logic [TW-1:0] rd_time,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] q_addr,
  output perm_e         q_perm,
  output logic [TW-1:0] q_time,
  output logic [DW-1:0] q_data
);
  perm_e         perm_a [LINES];
  logic [TW-1:0] time_a [LINES];
  logic [DW-1:0] data_a [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    perm_e         perm_r, perm_n;
    logic [TW-1:0] time_r, time_n;
    logic [DW-1:0] data_r, data_n;
    logic          sel;

    assign sel = wr_en && (wr_addr == AW'(i));

    always_comb begin
      perm_n = perm_r;
      time_n = time_r;
      data_n = data_r;
      if (sel) begin
        perm_n = wr_perm;
        time_n = wr_time;
        if (wr_data_en) data_n = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        perm_r <= PERM_NONE;
        time_r <= '0;
        data_r <= '0;
      end else begin
        perm_r <= perm_n;
        time_r <= time_n;
        data_r <= data_n;
      end
    end

    assign perm_a[i] = perm_r;
    assign time_a[i] = time_r;
    assign data_a[i] = data_r;
  end

  assign rd_perm = perm_a[rd_addr];
  assign rd_time = time_a[rd_addr];
  assign rd_data = data_a[rd_addr];
  assign q_perm  = perm_a[q_addr];
  assign q_time  = time_a[q_addr];
  assign q_data  = data_a[q_addr];
endmodule

// File: rtl/own_event_check.sv
module own_event_check
  import own_pkg::*;
#(
  parameter int TW = 8,
  parameter int DW = 32
) (
  input  logic          is_grant,
  input  logic [TW-1:0] ev_time,
  input  logic [DW-1:0] ev_data,
  input  logic [1:0]    ev_perm,
  input  perm_e         cur_perm,
  input  logic [TW-1:0] cur_time,
  input  logic [DW-1:0] cur_data,
  output logic          legal,
  output perm_e         nxt_perm,
  output logic          store_data
);
  logic time_ok, same_time, data_match, perm_ok, data_ok;

  assign time_ok    = ev_time >= cur_time;
  assign same_time  = ev_time == cur_time;
  assign data_match = ev_data == cur_data;

  always_comb begin
    if (is_grant) begin
      perm_ok    = (cur_perm == PERM_NONE) &&
                   ((ev_perm == 2'd1) || (ev_perm == 2'd2));
      data_ok    = !same_time || data_match;
      store_data = 1'b1;
      nxt_perm   = (ev_perm == 2'd2) ? PERM_EXCL : PERM_SHRD;
    end else begin
      perm_ok    = cur_perm != PERM_NONE;
      data_ok    = (cur_perm != PERM_EXCL) || !same_time || data_match;
      store_data = cur_perm == PERM_EXCL;
      nxt_perm   = PERM_NONE;
    end
  end

  assign legal = time_ok && perm_ok && data_ok;
endmodule

// File: rtl/own_local_clock.sv
module own_local_clock #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [TW-1:0] ev_time,
  output logic [TW-1:0] now
);
  logic [TW-1:0] now_n;

  always_comb begin
    now_n = now;
    if (adv && (ev_time > now)) now_n = ev_time;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now_n;
  end
endmodule

// File: rtl/own_tracker.sv
module own_tracker
  import own_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TW    = 8,
  parameter int DW    = 32,
  localparam int AW   = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gnt_valid,
  output logic          gnt_ready,
  input  logic [AW-1:0] gnt_addr,
  input  logic [TW-1:0] gnt_time,
  input  logic [DW-1:0] gnt_data,
  input  logic [1:0]    gnt_perm,
  input  logic          rel_valid,
  output logic          rel_ready,
  input  logic [AW-1:0] rel_addr,
  input  logic [TW-1:0] rel_time,
  input  logic [DW-1:0] rel_data,
  output logic          err_pulse,
  output logic [TW-1:0] local_time,
  input  logic [AW-1:0] qry_addr,
  output logic [1:0]    qry_perm,
  output logic [TW-1:0] qry_time,
  output logic [DW-1:0] qry_data
);
  logic          take_gnt, take_rel, take_any;
  logic [AW-1:0] ev_addr;
  logic [TW-1:0] ev_time;
  logic [DW-1:0] ev_data;
  perm_e         cur_perm, nxt_perm, q_perm;
  logic [TW-1:0] cur_time;
  logic [DW-1:0] cur_data;
  logic          legal, store_data, commit, err_n;

  assign gnt_ready = 1'b1;
  assign rel_ready = !gnt_valid;
  assign take_gnt  = gnt_valid;
  assign take_rel  = rel_valid && !gnt_valid;
  assign take_any  = take_gnt || take_rel;

  assign ev_addr = take_gnt ? gnt_addr : rel_addr;
  assign ev_time = take_gnt ? gnt_time : rel_time;
  assign ev_data = take_gnt ? gnt_data : rel_data;

  own_line_store #(.LINES(LINES), .TW(TW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(commit), .wr_addr(ev_addr), .wr_perm(nxt_perm), .wr_time(ev_time),
    .wr_data_en(store_data), .wr_data(ev_data),
    .rd_addr(ev_addr), .rd_perm(cur_perm), .rd_time(cur_time), .rd_data(cur_data),
    .q_addr(qry_addr), .q_perm(q_perm), .q_time(qry_time), .q_data(qry_data)
  );

  own_event_check #(.TW(TW), .DW(DW)) u_check (
    .is_grant(take_gnt), .ev_time(ev_time), .ev_data(ev_data), .ev_perm(gnt_perm),
    .cur_perm(cur_perm), .cur_time(cur_time), .cur_data(cur_data),
    .legal(legal), .nxt_perm(nxt_perm), .store_data(store_data)
  );

  assign commit = take_any && legal;
  assign err_n  = take_any && !legal;

  own_local_clock #(.TW(TW)) u_lclk (
    .clk(clk), .rst_n(rst_n), .adv(commit), .ev_time(ev_time), .now(local_time)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_pulse <= 1'b0;
    else        err_pulse <= err_n;
  end

  assign qry_perm = q_perm;
endmodule

// File: rtl/own_tracker_chk.sv
module own_tracker_chk #(
  parameter int LINES = 16,
  parameter int TW    = 8,
  parameter int DW    = 32,
  localparam int AW   = $clog2(LINES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gnt_valid,
  input logic          gnt_ready,
  input logic [1:0]    gnt_perm,
  input logic          rel_ready,
  input logic          err_pulse,
  input logic [TW-1:0] local_time,
  input logic [1:0]    qry_perm
);
  p_grant_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt_ready && !rel_ready));

  p_bad_perm_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && (gnt_perm == 2'd0 || gnt_perm == 2'd3)) |=> err_pulse);

  p_lclk_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (local_time >= $past(local_time)));

  p_err_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (local_time == $past(local_time)));

  p_perm_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    qry_perm != 2'd3);
endmodule

bind own_tracker own_tracker_chk #(.LINES(LINES), .TW(TW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt_valid(gnt_valid), .gnt_ready(gnt_ready),
  .gnt_perm(gnt_perm), .rel_ready(rel_ready), .err_pulse(err_pulse),
  .local_time(local_time), .qry_perm(qry_perm)
);

// File: tb/test_own_tracker.sv
module test_own_tracker;
  localparam int LINES = 16;
  localparam int TW = 8;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic gnt_valid = 0, rel_valid = 0;
  logic [AW-1:0] gnt_addr = 0, rel_addr = 0, qry_addr = 0;
  logic [TW-1:0] gnt_time = 0, rel_time = 0;
  logic [DW-1:0] gnt_data = 0, rel_data = 0;
  logic [1:0] gnt_perm = 0;
  logic gnt_ready, rel_ready, err_pulse;
  logic [TW-1:0] local_time, qry_time;
  logic [DW-1:0] qry_data;
  logic [1:0] qry_perm;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  own_tracker i_own_tracker (
    .clk(clk), .rst_n(rst_n),
    .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_addr(gnt_addr),
    .gnt_time(gnt_time), .gnt_data(gnt_data), .gnt_perm(gnt_perm),
    .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_addr(rel_addr),
    .rel_time(rel_time), .rel_data(rel_data),
    .err_pulse(err_pulse), .local_time(local_time),
    .qry_addr(qry_addr), .qry_perm(qry_perm), .qry_time(qry_time), .qry_data(qry_data)
  );

  // Behavioural reference model: plain arrays and integers
  int          m_perm [LINES];
  int          m_time [LINES];
  logic [31:0] m_data [LINES];
  int          m_local;
  bit          m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        m_perm[i] = 0; m_time[i] = 0; m_data[i] = 0;
      end
      m_local = 0;
      m_err = 0;
    end else begin
      bit ok;
      int a, t;
      ok = 1;
      m_err = 0;
      if (gnt_valid) begin
        a = gnt_addr; t = gnt_time;
        if (m_perm[a] != 0) ok = 0;
        if (gnt_perm != 1 && gnt_perm != 2) ok = 0;
        if (t < m_time[a]) ok = 0;
        if (t == m_time[a] && gnt_data != m_data[a]) ok = 0;
        if (ok) begin
          m_perm[a] = gnt_perm; m_time[a] = t; m_data[a] = gnt_data;
          if (t > m_local) m_local = t;
        end else m_err = 1;
      end else if (rel_valid) begin
        a = rel_addr; t = rel_time;
        if (m_perm[a] == 0) ok = 0;
        if (t < m_time[a]) ok = 0;
        if (m_perm[a] == 2 && t == m_time[a] && rel_data != m_data[a]) ok = 0;
        if (ok) begin
          if (m_perm[a] == 2) m_data[a] = rel_data;
          m_perm[a] = 0; m_time[a] = t;
          if (t > m_local) m_local = t;
        end else m_err = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(qry_perm == 2'(m_perm[qry_addr]), "R2 R3 line permission", qry_perm, m_perm[qry_addr]);
    chk(qry_time == 8'(m_time[qry_addr]), "R4 line timestamp", qry_time, m_time[qry_addr]);
    chk(qry_data == m_data[qry_addr], "R6 R9 line data copy", qry_data, m_data[qry_addr]);
    chk(local_time == 8'(m_local), "R5 local clock", local_time, m_local);
    chk(err_pulse == m_err, "R7 error pulse", err_pulse, m_err);
    chk(gnt_ready == 1'b1 && rel_ready == !gnt_valid, "R8 ready", {gnt_ready, rel_ready}, {1'b1, !gnt_valid});
  endtask

  // One cycle: compare at the falling edge, then drive the next event
  task automatic step(input bit gv, input int ga, input int gt, input logic [31:0] gd, input int gp,
                      input bit rv, input int ra, input int rt, input logic [31:0] rd);
    @(negedge clk);
    compare_all();
    qry_addr  = gv ? AW'(gnt_addr) : (rel_valid ? AW'(rel_addr) : qry_addr);
    gnt_valid = gv; gnt_addr = AW'(ga); gnt_time = TW'(gt); gnt_data = gd; gnt_perm = 2'(gp);
    rel_valid = rv; rel_addr = AW'(ra); rel_time = TW'(rt); rel_data = rd;
  endtask

  task automatic grant(input int a, input int t, input logic [31:0] d, input int p);
    step(1, a, t, d, p, 0, 0, 0, 0);
  endtask
  task automatic release_ev(input int a, input int t, input logic [31:0] d);
    step(0, 0, 0, 0, 0, 1, a, t, d);
  endtask
  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state of every line
    for (int i = 0; i < LINES; i++) begin
      @(negedge clk);
      qry_addr = AW'(i);
      #1;
      chk(qry_perm == 0 && qry_time == 0 && qry_data == 0, "R1 line reset", {qry_perm, qry_time}, 0);
    end
    chk(local_time == 0 && err_pulse == 0, "R1 local clock and error", local_time, 0);

    // R2 R6: legal exclusive grant at time 0 with the reset data value
    grant(3, 0, 32'h0, 2); idle();
    // R6: exclusive release at equal time, wrong data -> error
    release_ev(3, 0, 32'hDEAD); idle();
    // R6: exclusive release at later time stores new data
    release_ev(3, 5, 32'h1234_5678); idle();
    // R6: grant at equal time with matching data, shared
    grant(3, 5, 32'h1234_5678, 1); idle();
    // R9: shared release, garbage data ignored
    release_ev(3, 5, 32'hFFFF_0000); idle();
    // R2: perm codes 0 and 3 rejected
    grant(4, 1, 32'h0, 0); idle();
    grant(4, 1, 32'h0, 3); idle();
    // R2: grant to owned line rejected
    grant(4, 2, 32'hA, 2); grant(4, 3, 32'hB, 1); idle();
    // R4: time going backwards rejected
    release_ev(4, 1, 32'hA); idle();
    release_ev(4, 9, 32'hC); idle();
    // R3: release of unowned line rejected
    release_ev(7, 9, 32'h0); idle();
    // R6: grant at equal time, wrong data rejected
    grant(4, 9, 32'h5, 1); idle();
    // R5: event time below local clock keeps local clock
    grant(8, 2, 32'h77, 2); idle();
    // R8: both valid, grant wins, release held
    step(1, 9, 4, 32'h9, 1, 1, 8, 6, 32'h1); idle();
    step(0, 0, 0, 0, 0, 1, 8, 6, 32'h1); idle();

    // Random traffic concentrated on a few lines
    for (int n = 0; n < 4000; n++) begin
      int a, t, kind;
      logic [31:0] d;
      a = ($urandom % 2) ? int'($urandom % 4) : int'($urandom % LINES);
      t = m_time[a] + int'($urandom % 4) - 1;
      if (t < 0) t = 0;
      if (t > 255) t = 255;
      d = ($urandom % 2) ? m_data[a] : $urandom;
      kind = $urandom % 8;
      if (kind < 3)      grant(a, t, d, int'($urandom % 4) | ((($urandom % 4) != 0) ? 1 : 0));
      else if (kind < 6) release_ev(a, t, d);
      else if (kind < 7) step(1, a, t, d, 1 + int'($urandom % 2), 1, int'($urandom % LINES), t, d);
      else               idle();
    end
    idle(); idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule